// File: doc/BRIEF.md
# Logic Analyzer Sample Clock Qualifier

This block produces the sample-enable strobe for a logic analyzer capture path. It runs entirely on the fast system clock. In timing mode a programmable divider paces the strobe. In state mode the strobe follows rising edges of an external clock. That external clock is one of two inputs, or their AND, or their OR, so one clock's level can gate the sampling edges of the other. Gating this way cuts how much data reaches sample memory.

Both external clocks are treated as data. Each passes through a two-flop synchronizer, and edges are found on the synchronized, combined level. In timing mode the synchronized levels of both external clocks also leave the block as two auxiliary capture channels, channels 30 and 31 of the capture word, so the external clock waveforms can be viewed. The configuration (mode, source and rate) is taken from the inputs only while the arm input is low. Any change of configuration suppresses the strobe for one cycle, so that no false edge is reported.

Top module: `sample_clk_qualifier`

## Requirements
- R1: `mode_state` = 0 selects timing mode, where strobes come only from the internal divider. `mode_state` = 1 selects state mode, where strobes come only from rising edges of the selected external clock.
- R2: While `rst` is high, and after it, `sample_en` and `aux_chan` are 0. After reset the block is in timing mode with the default rate of 3, so it gives one strobe every 4 cycles until a configuration is loaded.
- R3: `src_sel` encodes the external source: 0 is clk1, 1 is clk2, 2 is clk1 AND clk2, 3 is clk1 OR clk2. In state mode a strobe fires on each rising edge of the selected combination, and activity on a clock that is not selected gives no strobe.
- R4: In AND mode a strobe can occur only while the synchronized clk1 is high. Edges of clk2 while clk1 is low are not sampled.
- R5: In state mode a strobe goes high exactly 3 system cycles after the input edge: two synchronizer stages, then one cycle of strobe latency. It is exactly one cycle wide.
- R6: In state mode, with no change on the external clocks, `sample_en` stays 0.
- R7: In timing mode with rate value N (16 bits), the strobe fires once every N+1 system cycles. N = 0 gives a strobe every cycle.
- R8: `aux_chan[0]` carries the synchronized clk1 (capture channel 30) and `aux_chan[1]` carries the synchronized clk2 (channel 31). These follow in timing mode with the same 3-cycle latency, and are held at 0 in state mode.
- R9: `mode_state`, `src_sel` and `rate` are taken on a clock edge only while `arm` is low. While `arm` is high, changes on them have no effect.
- R10: A configuration change never produces a strobe in the cycle that follows it, even when the newly selected source is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | High freezes the configuration; low loads it from the inputs |
| mode_state | input | 1 | 0 = timing mode, 1 = state mode |
| src_sel | input | 2 | External source: 0 clk1, 1 clk2, 2 AND, 3 OR |
| rate | input | 16 | Timing divider value N; period is N+1 cycles |
| ext_clk1 | input | 1 | External clock 1, asynchronous |
| ext_clk2 | input | 1 | External clock 2, asynchronous |
| sample_en | output | 1 | Registered one-cycle sample strobe |
| aux_chan | output | 2 | Synchronized clk1 / clk2 levels for capture channels 30 / 31 |

## Verification
A state-mode strobe is due at the third rising clock edge after the external input changes. Auxiliary channels follow on the same schedule, and a new configuration takes effect one edge after it is presented with `arm` low. The bench drives every input at a falling edge and, for each rising edge of the modelled combined clock, computes the cycle number at which the strobe must appear and queues it. The monitor compares each observed strobe against the head of that queue at falling edges, and flags both strobes that arrive early or without cause and expected strobes that never come. Timing mode is checked by the distance between consecutive strobes rather than by absolute phase, and the effect of `arm` and of configuration changes is checked by counting strobes within fixed windows.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
  typedef enum logic [1:0] {
    SRC_CLK1 = 2'd0,
    SRC_CLK2 = 2'd1,
    SRC_AND  = 2'd2,
    SRC_OR   = 2'd3
  } src_e;

  localparam int EXT_N = 2;
endpackage

// File: rtl/sqc_sync.sv
module sqc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sqc_rate_div.sv
module sqc_rate_div #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [RATE_W-1:0] cnt;
  logic              at_end;

  assign at_end = (cnt == rate);
  assign tick   = en && !clr && at_end;

  always_ff @(posedge clk) begin
    if (rst || clr || !en) cnt <= '0;
    else if (at_end)       cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sqc_edge_qual.sv
module sqc_edge_qual
  import sqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [EXT_N-1:0] lvl,
  input  src_e             src,
  output logic             comb_lvl,
  output logic             rise
);
  logic prev;

  always_comb begin
    unique case (src)
      SRC_CLK1: comb_lvl = lvl[0];
      SRC_CLK2: comb_lvl = lvl[1];
      SRC_AND:  comb_lvl = lvl[0] & lvl[1];
      default:  comb_lvl = lvl[0] | lvl[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= comb_lvl;
  end

  assign rise = comb_lvl && !prev;
endmodule

// File: rtl/sample_clk_qualifier.sv
module sample_clk_qualifier
  import sqc_pkg::*;
#(
  parameter int               RATE_W     = 16,
  parameter int               SYNC_STG   = 2,
  parameter logic [RATE_W-1:0] RST_RATE  = 16'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              mode_state,
  input  logic [1:0]        src_sel,
  input  logic [RATE_W-1:0] rate,
  input  logic              ext_clk1,
  input  logic              ext_clk2,
  output logic              sample_en,
  output logic [EXT_N-1:0]  aux_chan
);
  logic              mode_q;
  src_e              src_q;
  logic [RATE_W-1:0] rate_q;
  logic              cfg_diff;
  logic              flush_q;
  logic [EXT_N-1:0]  lvl;
  logic              comb_lvl;
  logic              rise;
  logic              tick;

  // configuration capture, open only while arm is low
  assign cfg_diff = !arm && ((mode_state != mode_q) ||
                             (src_e'(src_sel) != src_q) ||
                             (rate != rate_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      src_q   <= SRC_CLK1;
      rate_q  <= RST_RATE;
      flush_q <= 1'b0;
    end else begin
      flush_q <= cfg_diff;
      if (!arm) begin
        mode_q <= mode_state;
        src_q  <= src_e'(src_sel);
        rate_q <= rate;
      end
    end
  end

  sqc_sync #(.WIDTH(EXT_N), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_clk2, ext_clk1}),
    .q   (lvl)
  );

  sqc_edge_qual u_edge (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl),
    .src      (src_q),
    .comb_lvl (comb_lvl),
    .rise     (rise)
  );

  sqc_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (!mode_q),
    .clr  (flush_q),
    .rate (rate_q),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_en <= 1'b0;
      aux_chan  <= '0;
    end else begin
      sample_en <= mode_q ? (rise && !flush_q) : tick;
      aux_chan  <= mode_q ? '0 : lvl;
    end
  end
endmodule

// File: rtl/sample_clk_qualifier_chk.sv
module sample_clk_qualifier_chk
  import sqc_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              arm,
  input logic              sample_en,
  input logic [EXT_N-1:0]  aux_chan,
  input logic              mode_q,
  input src_e              src_q,
  input logic [RATE_W-1:0] rate_q,
  input logic [EXT_N-1:0]  lvl,
  input logic              comb_lvl
);
  p_reset_timing_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mode_q);

  p_and_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_en && $past(mode_q) && ($past(src_q) == SRC_AND)) |-> $past(lvl[0]));

  p_one_wide_r5: assert property (@(posedge clk) disable iff (rst)
    (sample_en && mode_q) |=> !sample_en);

  p_edge_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (sample_en && $past(mode_q)) |-> ($past(comb_lvl) && !$past(comb_lvl, 2)));

  p_aux_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(mode_q) |-> (aux_chan == '0));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    arm |=> ($stable(mode_q) && $stable(src_q) && $stable(rate_q)));
endmodule

bind sample_clk_qualifier sample_clk_qualifier_chk #(.RATE_W(RATE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .arm       (arm),
  .sample_en (sample_en),
  .aux_chan  (aux_chan),
  .mode_q    (mode_q),
  .src_q     (src_q),
  .rate_q    (rate_q),
  .lvl       (lvl),
  .comb_lvl  (comb_lvl)
);

// File: tb/sample_clk_qualifier_bench.sv
module sample_clk_qualifier_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b1;
  logic        mode_state = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [15:0] rate = 16'd3;
  logic        ext_clk1 = 1'b0;
  logic        ext_clk2 = 1'b0;
  logic        sample_en;
  logic [1:0]  aux_chan;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int strobe_cnt = 0;
  bit sb_on = 0;
  bit done = 0;
  bit eff_state = 0;
  logic [1:0] eff_src = 2'd0;
  string cur_req = "R3";
  int exp_q[$];

  sample_clk_qualifier u_sample_clk_qualifier (
    .clk(clk), .rst(rst), .arm(arm), .mode_state(mode_state),
    .src_sel(src_sel), .rate(rate), .ext_clk1(ext_clk1), .ext_clk2(ext_clk2),
    .sample_en(sample_en), .aux_chan(aux_chan)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic comb_f(logic [1:0] s, logic a, logic b);
    case (s)
      2'd0: return a;
      2'd1: return b;
      2'd2: return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && sample_en) strobe_cnt++;
    if (!rst && sb_on) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        check(0, cur_req, 0, exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (sample_en) begin
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          check(1, cur_req, cyc, cyc);
          void'(exp_q.pop_front());
        end else begin
          check(0, cur_req, cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end
    end
  end

  task automatic drive_ext(input logic a, input logic b);
    logic o, n;
    @(negedge clk);
    o = comb_f(eff_src, ext_clk1, ext_clk2);
    n = comb_f(eff_src, a, b);
    if (sb_on && eff_state && !o && n) exp_q.push_back(cyc + 3);
    ext_clk1 = a;
    ext_clk2 = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cfg(input logic m, input logic [1:0] s, input logic [15:0] r);
    bit keep;
    keep = eff_state && m;
    @(negedge clk);
    if (!keep) sb_on = 0;
    mode_state = m; src_sel = s; rate = r; arm = 0;
    @(negedge clk);
    arm = 1; eff_state = m; eff_src = s;
    repeat (3) @(negedge clk);
    sb_on = m;
  endtask

  task automatic measure(input int exp, input string req);
    int t1, t2, guard;
    t1 = -1; t2 = -1; guard = 0;
    while (t1 < 0 && guard < 200) begin
      @(negedge clk); guard++;
      if (sample_en) t1 = cyc;
    end
    while (t2 < 0 && guard < 400) begin
      @(negedge clk); guard++;
      if (sample_en) t2 = cyc;
    end
    check(t1 >= 0 && t2 >= 0 && (t2 - t1) == exp, req, t2 - t1, exp);
  endtask

  task automatic quiet_window(input int n, input string req);
    int c0;
    c0 = strobe_cnt;
    repeat (n) @(negedge clk);
    check(strobe_cnt == c0, req, strobe_cnt - c0, 0);
  endtask

  task automatic drain(input string req);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    check(sample_en == 1'b0, "R2", sample_en, 0);
    check(aux_chan == 2'b00, "R2", aux_chan, 0);
    rst = 0;
    measure(4, "R2");

    // R1 / R7: timing divider rates
    set_cfg(1'b0, 2'd0, 16'd4);
    measure(5, "R1");
    set_cfg(1'b0, 2'd0, 16'd1);
    measure(2, "R7");
    set_cfg(1'b0, 2'd0, 16'd0);
    measure(1, "R7");
    set_cfg(1'b0, 2'd0, 16'd9);
    measure(10, "R7");

    // R8: aux channels in timing mode, 3-cycle latency
    @(negedge clk); ext_clk1 = 1; ext_clk2 = 0;
    repeat (2) @(negedge clk);
    check(aux_chan == 2'b00, "R8", aux_chan, 0);
    @(negedge clk);
    check(aux_chan == 2'b01, "R8", aux_chan, 1);
    drive_ext(1'b0, 1'b1);
    check(aux_chan == 2'b10, "R8", aux_chan, 2);
    drive_ext(1'b1, 1'b1);
    check(aux_chan == 2'b11, "R8", aux_chan, 3);
    drive_ext(1'b0, 1'b0);

    // R3 / R5: clk1 source
    set_cfg(1'b1, 2'd0, 16'd4);
    cur_req = "R5";
    for (int i = 0; i < 4; i++) begin
      drive_ext(1'b1, 1'b0);
      drive_ext(1'b0, 1'b0);
    end
    check(aux_chan == 2'b00, "R8", aux_chan, 0);
    cur_req = "R3";
    drive_ext(1'b0, 1'b1);
    drive_ext(1'b0, 1'b0);
    drain("R3");

    // R6: idle
    quiet_window(40, "R6");

    // R4: AND source
    set_cfg(1'b1, 2'd2, 16'd4);
    cur_req = "R4";
    drive_ext(1'b0, 1'b1);
    drive_ext(1'b0, 1'b0);
    drive_ext(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      drive_ext(1'b1, 1'b1);
      drive_ext(1'b1, 1'b0);
    end
    drive_ext(1'b0, 1'b1);
    drive_ext(1'b1, 1'b1);
    drive_ext(1'b0, 1'b0);
    drain("R4");

    // R3: OR source
    set_cfg(1'b1, 2'd3, 16'd4);
    cur_req = "R3";
    drive_ext(1'b1, 1'b0);
    drive_ext(1'b1, 1'b1);
    drive_ext(1'b1, 1'b0);
    drive_ext(1'b0, 1'b0);
    drive_ext(1'b0, 1'b1);
    drive_ext(1'b0, 1'b0);
    drain("R3");

    // R3: clk2 source
    set_cfg(1'b1, 2'd1, 16'd4);
    drive_ext(1'b1, 1'b0);
    drive_ext(1'b0, 1'b0);
    drive_ext(1'b0, 1'b1);
    drive_ext(1'b0, 1'b0);
    drain("R3");

    // R10: switch to an already-high source
    cur_req = "R10";
    set_cfg(1'b1, 2'd0, 16'd4);
    drive_ext(1'b0, 1'b1);
    begin
      int c0;
      c0 = strobe_cnt;
      set_cfg(1'b1, 2'd1, 16'd4);
      repeat (4) @(negedge clk);
      check(strobe_cnt == c0, "R10", strobe_cnt - c0, 0);
    end
    drive_ext(1'b0, 1'b0);
    drive_ext(1'b0, 1'b1);
    drive_ext(1'b0, 1'b0);
    drain("R10");

    // R9: arm high freezes configuration (clk2 state mode)
    cur_req = "R9";
    @(negedge clk);
    mode_state = 0; src_sel = 2'd3; rate = 16'd0;
    begin
      int c0;
      c0 = strobe_cnt;
      drive_ext(1'b1, 1'b0);
      drive_ext(1'b0, 1'b0);
      check(strobe_cnt == c0, "R9", strobe_cnt - c0, 0);
      check(aux_chan == 2'b00, "R9", aux_chan, 0);
    end
    drive_ext(1'b0, 1'b1);
    drive_ext(1'b0, 1'b0);
    drain("R9");

    // R1: back to timing mode, external edges ignored
    set_cfg(1'b0, 2'd0, 16'd6);
    measure(7, "R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule